// File: doc/BRIEF.md
# Line Transfer and Dot-Inversion Polarity Unit

This block sits between the per-line sample registers of a panel column driver and its output stage. It keeps a hold bank of 6-bit grey codes that drives the current line, while the sample bank in front of it fills for the next line. A load strobe detected on the clock copies the whole sample bank into the hold bank, whatever it contains at that moment. The same load event captures a polarity select and a channel-count mode.

From the captured values the block produces three things for every channel. The first is the code. The second is a drive-polarity bit: positive uses the upper reference range, negative the lower one. The third is an enable flag, which marks the channels that do not exist in the reduced-channel mode.

Polarity alternates between odd and even channels. In the reduced mode the missing block of channels would break that alternation. To keep it intact, the polarity of every channel above the missing block is inverted.

Top module: `lineXferTop`

## Requirements
- R1: When `ldIn` is sampled high on a clock edge after being sampled low on the edge before, that edge copies `sampleBank` into the hold bank. The copy appears on `holdCodes` right after that edge and uses whatever `sampleBank` holds then. Channel n (1-based) occupies bits [(n-1)*6 +: 6] of both vectors.
- R2: `holdCodes` changes only on a load edge. Holding `ldIn` high, or changing `sampleBank` between loads, has no effect on it.
- R3: `polSel` is captured only on a load edge. Changes to it at any other time leave `chPositive` unchanged.
- R4: With captured polarity 1 in full mode, odd channels report `chPositive`=1 (upper range) and even channels report 0 (lower range).
- R5: With captured polarity 0 in full mode, odd channels report 0 and even channels report 1.
- R6: In reduced mode (`reducedMode`=1 captured), channels 151 to 159 report `chEnable`=0 and all other channels report 1. In full mode every channel reports 1.
- R7: In reduced mode, channels 160 and above take the inverse of the R4/R5 polarity, so that channel 150 and channel 160 have opposite polarity. Channels 1 to 159 follow R4/R5.
- R8: `reducedMode` is captured only on a load edge. Changes to it at any other time alter neither `chEnable` nor `chPositive`.
- R9: During and after reset, before any load, the hold bank is all zero, the captured polarity is 0 and the mode is full.
- R10: Codes pass unmodified over the whole range 00 to 3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldIn | input | 1 | Load strobe; a rising level transfers the line |
| polSel | input | 1 | Polarity select, captured at load |
| reducedMode | input | 1 | 1 selects the reduced channel count, captured at load |
| sampleBank | input | NUM_CH*CODE_W | Codes of the line being sampled |
| holdCodes | output | NUM_CH*CODE_W | Codes driving the current line |
| chPositive | output | NUM_CH | Per-channel polarity, 1 = upper range |
| chEnable | output | NUM_CH | Per-channel availability flag |

## Verification
Every result of this block follows the clock edge at which `ldIn` is first seen high, with one register in the path. The bench raises `ldIn` on a falling edge and lowers it on the next falling edge. It then compares codes, polarity and enables at that second falling edge, one cycle after the stimulus. The no-effect cases (R2, R3, R8) change inputs on falling edges without a rising `ldIn`. Outputs are checked one full cycle later, which is long enough for a wrong design to have reacted.

// File: rtl/lineXferPkg.sv
package lineXferPkg;

  // Control to datapath: one strobe plus the captured line settings.
  typedef struct packed {
    logic loadNow;        // high in the cycle a load edge is seen
    logic polLatched;     // polarity captured at the last load
    logic reducedLatched; // channel-count mode captured at the last load
  } lineCtrl_t;

endpackage

// File: rtl/lineXferCtrl.sv
module lineXferCtrl
  import lineXferPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ldIn,
  input  logic      polSel,
  input  logic      reducedMode,
  output lineCtrl_t ctrl
);

  logic ldPrev;
  logic polQ;
  logic redQ;
  logic loadEdge;

  // ldPrev follows ldIn even in reset, so a level that is already high
  // when reset ends is not taken as an edge.
  assign loadEdge = ldIn & ~ldPrev & rstN;

  always_ff @(posedge clk) begin
    ldPrev <= ldIn;
    if (!rstN) begin
      polQ <= 1'b0;
      redQ <= 1'b0;
    end else if (loadEdge) begin
      polQ <= polSel;
      redQ <= reducedMode;
    end
  end

  always_comb begin
    ctrl.loadNow        = loadEdge;
    ctrl.polLatched     = polQ;
    ctrl.reducedLatched = redQ;
  end

endmodule

// File: rtl/lineXferData.sv
module lineXferData
  import lineXferPkg::*;
#(
  parameter int NUM_CH    = 309,
  parameter int CODE_W    = 6,
  parameter int GAP_FIRST = 151,
  parameter int GAP_LAST  = 159
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lineCtrl_t                ctrl,
  input  logic [NUM_CH*CODE_W-1:0] sampleBank,
  output logic [NUM_CH*CODE_W-1:0] holdCodes,
  output logic [NUM_CH-1:0]        chPositive,
  output logic [NUM_CH-1:0]        chEnable
);

  localparam int BANK_W = NUM_CH * CODE_W;

  logic [BANK_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rstN)
      holdReg <= '0;
    else if (ctrl.loadNow)
      holdReg <= sampleBank;
  end

  assign holdCodes = holdReg;

  // Each channel's parity and its position relative to the gap are fixed
  // at elaboration, so each channel needs only an XOR and an AND.
  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    localparam int CH_NUM    = g + 1;
    localparam bit IS_ODD    = (CH_NUM % 2) == 1;
    localparam bit ABOVE_GAP = CH_NUM > GAP_LAST;
    localparam bit IN_GAP    = (CH_NUM >= GAP_FIRST) && (CH_NUM <= GAP_LAST);

    logic basePos;
    assign basePos = IS_ODD ? ctrl.polLatched : ~ctrl.polLatched;

    if (ABOVE_GAP) begin : gAbove
      assign chPositive[g] = basePos ^ ctrl.reducedLatched;
    end else begin : gBelow
      assign chPositive[g] = basePos;
    end

    if (IN_GAP) begin : gGap
      assign chEnable[g] = ~ctrl.reducedLatched;
    end else begin : gLive
      assign chEnable[g] = 1'b1;
    end
  end

endmodule

// File: rtl/lineXferTop.sv
module lineXferTop
  import lineXferPkg::*;
#(
  parameter int NUM_CH    = 309,
  parameter int CODE_W    = 6,
  parameter int GAP_FIRST = 151,
  parameter int GAP_LAST  = 159
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ldIn,
  input  logic                     polSel,
  input  logic                     reducedMode,
  input  logic [NUM_CH*CODE_W-1:0] sampleBank,
  output logic [NUM_CH*CODE_W-1:0] holdCodes,
  output logic [NUM_CH-1:0]        chPositive,
  output logic [NUM_CH-1:0]        chEnable
);

  lineCtrl_t ctrl;

  lineXferCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ldIn       (ldIn),
    .polSel     (polSel),
    .reducedMode(reducedMode),
    .ctrl       (ctrl)
  );

  lineXferData #(
    .NUM_CH   (NUM_CH),
    .CODE_W   (CODE_W),
    .GAP_FIRST(GAP_FIRST),
    .GAP_LAST (GAP_LAST)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .sampleBank(sampleBank),
    .holdCodes (holdCodes),
    .chPositive(chPositive),
    .chEnable  (chEnable)
  );

endmodule

// File: rtl/lineXferChecker.sv
module lineXferChecker #(
  parameter int NUM_CH    = 309,
  parameter int CODE_W    = 6,
  parameter int GAP_FIRST = 151,
  parameter int GAP_LAST  = 159
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     ldIn,
  input logic [NUM_CH*CODE_W-1:0] sampleBank,
  input logic [NUM_CH*CODE_W-1:0] holdCodes,
  input logic [NUM_CH-1:0]        chPositive,
  input logic [NUM_CH-1:0]        chEnable
);

  localparam int GAP_LEN = GAP_LAST - GAP_FIRST + 1;

  // R1: a rising ldIn transfers the sampled bank
  p_load_copies_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ldIn && !$past(ldIn)) |=> (holdCodes == $past(sampleBank)));

  // R2: no rising ldIn, no change to the hold bank
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(ldIn && !$past(ldIn)) |=> $stable(holdCodes));

  // R3 / R8: polarity and enables move only at a load
  p_pol_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(ldIn && !$past(ldIn)) |=> ($stable(chPositive) && $stable(chEnable)));

  // R4 / R5: neighbours alternate while every channel is live
  p_alternate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (&chEnable) |-> (chPositive[0] != chPositive[1]));

  // R6: either every channel is live or exactly the gap is off
  p_gap_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(chEnable) == NUM_CH) || ($countones(chEnable) == NUM_CH - GAP_LEN));

  // R7: across the gap the alternation continues
  p_bridge_r7: assert property (@(posedge clk) disable iff (!rstN)
    !chEnable[GAP_FIRST-1] |-> (chPositive[GAP_FIRST-2] != chPositive[GAP_LAST]));

endmodule

bind lineXferTop lineXferChecker #(
  .NUM_CH   (NUM_CH),
  .CODE_W   (CODE_W),
  .GAP_FIRST(GAP_FIRST),
  .GAP_LAST (GAP_LAST)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ldIn      (ldIn),
  .sampleBank(sampleBank),
  .holdCodes (holdCodes),
  .chPositive(chPositive),
  .chEnable  (chEnable)
);

// File: tb/lineXferTop_test.sv
`timescale 1ns/1ps
module lineXferTop_test;

  localparam int NUM_CH = 309;
  localparam int CODE_W = 6;
  localparam int BANK_W = NUM_CH * CODE_W;
  localparam int NVEC   = 8;

  // Vector layout: {polarity, reduced, seed[7:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_00010001, 10'b0_0_00100101, 10'b1_1_01010011, 10'b0_1_11000111,
    10'b1_0_11111111, 10'b0_1_00000000, 10'b1_1_10101010, 10'b0_0_01111110
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldIn = 1'b0;
  logic polSel = 1'b0;
  logic reducedMode = 1'b0;
  logic [BANK_W-1:0] sampleBank = '0;
  logic [BANK_W-1:0] holdCodes;
  logic [NUM_CH-1:0] chPositive;
  logic [NUM_CH-1:0] chEnable;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lineXferTop uut (
    .clk(clk), .rstN(rstN), .ldIn(ldIn), .polSel(polSel),
    .reducedMode(reducedMode), .sampleBank(sampleBank),
    .holdCodes(holdCodes), .chPositive(chPositive), .chEnable(chEnable)
  );

  function automatic logic [BANK_W-1:0] makeBank(input logic [7:0] seed);
    logic [BANK_W-1:0] b;
    b = '0;
    for (int c = 0; c < NUM_CH; c++)
      b[c*CODE_W +: CODE_W] = 6'((int'(seed) + c * 7) & 63);
    return b;
  endfunction

  function automatic logic [NUM_CH-1:0] expPos(input logic pol, input logic red);
    logic [NUM_CH-1:0] v;
    for (int c = 1; c <= NUM_CH; c++) begin
      v[c-1] = (c % 2 == 1) ? pol : ~pol;
      if (red && c >= 160) v[c-1] = ~v[c-1];
    end
    return v;
  endfunction

  function automatic logic [NUM_CH-1:0] expEn(input logic red);
    logic [NUM_CH-1:0] v;
    for (int c = 1; c <= NUM_CH; c++)
      v[c-1] = !(red && c >= 151 && c <= 159);
    return v;
  endfunction

  task automatic checkAll(input string req, input logic [BANK_W-1:0] eCodes,
                          input logic pol, input logic red);
    logic [NUM_CH-1:0] eP;
    logic [NUM_CH-1:0] eE;
    eP = expPos(pol, red);
    eE = expEn(red);
    checks += 3;
    if (holdCodes !== eCodes) begin
      errors++;
      $display("FAIL %s codes: actual %h expected %h", req, holdCodes, eCodes);
    end
    if (chPositive !== eP) begin
      errors++;
      $display("FAIL %s polarity: actual %h expected %h", req, chPositive, eP);
    end
    if (chEnable !== eE) begin
      errors++;
      $display("FAIL %s enable: actual %h expected %h", req, chEnable, eE);
    end
  endtask

  task automatic pulseLoad();
    @(negedge clk) ldIn = 1'b1;
    @(negedge clk) ldIn = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    logic [BANK_W-1:0] lastCodes;
    sampleBank = makeBank(8'h5A);
    polSel = 1'b1;
    reducedMode = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R9 in reset", '0, 1'b0, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkAll("R9 after reset", '0, 1'b0, 1'b0);

    // Table walk: R1, R4, R5, R6, R7
    for (int i = 0; i < NVEC; i++) begin
      sampleBank  = makeBank(VEC[i][7:0]);
      polSel      = VEC[i][9];
      reducedMode = VEC[i][8];
      pulseLoad();
      checkAll(VEC[i][8] ? "R1 R6 R7 vector" : "R1 R4 R5 vector",
               makeBank(VEC[i][7:0]), VEC[i][9], VEC[i][8]);
    end

    // R2: ldIn held high, bank changes, no further transfer
    sampleBank = makeBank(8'h11); polSel = 1'b1; reducedMode = 1'b0;
    pulseLoad();
    lastCodes = makeBank(8'h11);
    @(negedge clk) ldIn = 1'b1;
    @(negedge clk) sampleBank = makeBank(8'h99);
    repeat (3) @(negedge clk);
    checkAll("R2 held level", lastCodes, 1'b1, 1'b0);
    ldIn = 1'b0;
    sampleBank = makeBank(8'h33);
    repeat (2) @(negedge clk);
    checkAll("R2 bank change", lastCodes, 1'b1, 1'b0);

    // R3: polarity change without load
    polSel = 1'b0;
    repeat (2) @(negedge clk);
    checkAll("R3 no capture", lastCodes, 1'b1, 1'b0);

    // R8: mode change without load
    reducedMode = 1'b1;
    repeat (2) @(negedge clk);
    checkAll("R8 no capture", lastCodes, 1'b1, 1'b0);
    pulseLoad();
    checkAll("R8 captured at load", makeBank(8'h33), 1'b0, 1'b1);

    // R10: extremes of the code range
    sampleBank = '1; polSel = 1'b1; reducedMode = 1'b0;
    pulseLoad();
    checkAll("R10 all 3F", '1, 1'b1, 1'b0);
    sampleBank = '0;
    pulseLoad();
    checkAll("R10 all 00", '0, 1'b1, 1'b0);

    // R7 boundary: channels 150 and 160 in reduced mode
    reducedMode = 1'b1; polSel = 1'b1;
    pulseLoad();
    checks++;
    if (chPositive[149] === chPositive[159] || chPositive[159] !== 1'b1) begin
      errors++;
      $display("FAIL R7 bridge: actual %b/%b expected 0/1", chPositive[149], chPositive[159]);
    end

    // R9: reset mid-run clears everything
    sampleBank = makeBank(8'h42); pulseLoad();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    checkAll("R9 re-reset", '0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule